// File: doc/BRIEF.md
# Bit-Stuffed Frame Receiver

This block takes a serial bit stream, one bit for each cycle in which a receive-bit strobe is high, and recovers the characters carried inside bit-stuffed frames. After a reset or a clear it watches the line until it sees a flag pattern. It then removes every zero that a sender inserted after five ones, and it builds characters of a programmable length. Each finished character goes into a buffer register. A flag that arrives after data closes the frame. A run of seven or more ones is treated as an abort and sends the receiver back to looking for a flag.

Flags and stuffed zeros are removed as the stream arrives. Each incoming bit passes through a seven-stage delay window, so that the bits of a flag are recognised before any of them can reach the character register. The character length is sampled again at each flag and at each completed character, so a frame may carry characters of different lengths. When a frame closes part way through a character, the partial value is copied to the buffer with a zero marker below the received bits. The character-loaded indication is not raised in that case.

Top module: `bitframe_rx`

## Requirements
- R1: After reset, and one cycle after `rx_clear`, every output is 0 and the receiver is hunting. While hunting it assembles no character, however many data bits arrive, until it has seen a flag.
- R2: A flag is a 0, then six 1s, then a 0, counting strobed bits only. While synchronized, a seventh consecutive 1 sets `abort_seen` and returns the receiver to hunting. Runs of ones while hunting leave `abort_seen` at 0.
- R3: A 0 that follows exactly five consecutive 1s is discarded and does not become a data bit.
- R4: `len_sel` codes 0, 1, 2 and 3 select characters of 5, 6, 7 and 8 bits. Bits arrive LSB first. A completed character appears in the low bits of `rx_char` with the upper bits at 0, and `char_loaded` is set.
- R5: The length is sampled from `len_sel` at each flag and at each completed character. It applies to the next character only.
- R6: `overrun` is set when a completed character or a frame-end copy is written to `rx_char` while `char_loaded` is already 1.
- R7: A flag that follows at least one accepted data bit sets `frame_end` and copies the partial character to `rx_char`. The `k` received bits sit in the top `k` of the `L` character positions, with a 0 just below them and 1s below that. For `k` = 0 the value is 2^(L-1)-1. `char_loaded` is not changed by this copy.
- R8: Flags that follow one another with no data between them produce no character and do not set `frame_end`.
- R9: `zero_err` is set on a closing flag when the last 13 strobed bits, oldest first, are 1111101111110. This is the case where the opening 0 of the flag is the only 0 that follows the final five data ones.
- R10: All five flags stay set until `rx_clear`. `rx_clear` clears them and the buffer, and forces hunting.
- R11: Outputs change only on a clock edge at which `bit_stb` or `rx_clear` is high. Each bit's effect is visible one cycle after its strobe.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_clear | input | 1 | Single-cycle clear of all flags; resynchronize |
| bit_stb | input | 1 | Receive-bit strobe; `rx_bit` is taken when high |
| rx_bit | input | 1 | Serial data in |
| len_sel | input | 2 | Character length code (0..3 gives 5..8 bits) |
| rx_char | output | 8 | Received character or partial-frame value |
| char_loaded | output | 1 | A complete character was written to `rx_char` |
| overrun | output | 1 | A write to `rx_char` happened while `char_loaded` was set |
| frame_end | output | 1 | A closing flag was seen |
| abort_seen | output | 1 | Seven or more ones were seen while synchronized |
| zero_err | output | 1 | A closing flag consumed the zero owed after five ones |

## Verification
Three situations are hard to reach from the ports.

- **Zero-error pattern.** A correct sender never produces it, so the bench writes five unstuffed ones straight into the bit stream just ahead of a closing flag.
- **Length change inside a frame.** The length is sampled at the exact strobe where the previous character leaves the seven-stage window. The bench therefore counts strobes from the character's last data bit and changes `len_sel` in the interval between the opening flag and that strobe.
- **Character completion.** A character only becomes visible seven strobes after its last bit. The bench samples at that strobe, which lets it read every length and value before the closing flag overwrites the buffer.

// File: rtl/bitframe_rx_pkg.sv
`timescale 1ns/1ps
package bitframe_rx_pkg;

    localparam int unsigned MIN_LEN  = 5;
    localparam int unsigned MAX_LEN  = 8;
    localparam int unsigned CODE_W   = 2;
    localparam int unsigned SR_W     = MAX_LEN + 1;
    localparam int unsigned IDX_W    = $clog2(SR_W);
    localparam int unsigned FLAG_RUN = 6;
    localparam int unsigned WIN_D    = FLAG_RUN + 1;
    localparam int unsigned HIST_W   = 2 * FLAG_RUN + 1;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SYNC = 2'd1,
        ST_ASM  = 2'd2
    } rx_state_e;

    typedef struct packed {
        rx_state_e           st;
        logic [SR_W-1:0]     sr;
        logic [CODE_W-1:0]   len;
        logic [MAX_LEN-1:0]  chr;
        logic                loaded;
        logic                ovr;
        logic                fend;
        logic                abrt;
        logic                zerr;
    } rx_regs_t;

    // Shift register seed: ones below the selected length, zero at and above it.
    function automatic logic [SR_W-1:0] sr_seed(input logic [CODE_W-1:0] code);
        logic [SR_W-1:0] v;
        v = '0;
        for (int i = 0; i < int'(MAX_LEN); i++) begin
            v[i] = (i < int'(MIN_LEN) + int'(code));
        end
        return v;
    endfunction

endpackage

// File: rtl/bitframe_rx_linemon.sv
`timescale 1ns/1ps
module bitframe_rx_linemon
    import bitframe_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic bit_in,
    output logic flag_hit,
    output logic abort_hit,
    output logic stuff_hit,
    output logic zerr_hit
);
    localparam int unsigned PREV_W = HIST_W - 1;
    // Oldest first: 11111 0 111111 (the incoming 0 completes the 13 bits).
    localparam logic [PREV_W-1:0] ZERR_PAT =
        {{(FLAG_RUN-1){1'b1}}, 1'b0, {FLAG_RUN{1'b1}}};

    logic [PREV_W-1:0] hist_q, hist_d;

    always_comb begin
        hist_d = hist_q;
        if (clr) begin
            hist_d = '0;
        end else if (stb) begin
            hist_d = {hist_q[PREV_W-2:0], bit_in};
        end
        flag_hit  = stb && !bit_in &&
                    (hist_q[FLAG_RUN:0] == {1'b0, {FLAG_RUN{1'b1}}});
        abort_hit = stb && bit_in && (&hist_q[FLAG_RUN-1:0]);
        stuff_hit = stb && !bit_in &&
                    (hist_q[FLAG_RUN-1:0] == {1'b0, {(FLAG_RUN-1){1'b1}}});
        zerr_hit  = flag_hit && (hist_q == ZERR_PAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

endmodule

// File: rtl/bitframe_rx_window.sv
`timescale 1ns/1ps
module bitframe_rx_window #(
    parameter int unsigned DEPTH = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic bit_in,
    input  logic keep_in,
    input  logic flush,
    output logic out_bit,
    output logic out_ok
);
    logic [DEPTH-1:0] bits_q, bits_d;
    logic [DEPTH-1:0] ok_q,   ok_d;

    always_comb begin
        bits_d = bits_q;
        ok_d   = ok_q;
        if (clr) begin
            ok_d = '0;
        end else if (stb) begin
            bits_d = {bits_q[DEPTH-2:0], bit_in};
            ok_d   = flush ? '0 : {ok_q[DEPTH-2:0], keep_in};
        end
        out_bit = bits_q[DEPTH-1];
        out_ok  = ok_q[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            ok_q   <= '0;
        end else begin
            bits_q <= bits_d;
            ok_q   <= ok_d;
        end
    end

endmodule

// File: rtl/bitframe_rx.sv
`timescale 1ns/1ps
module bitframe_rx
    import bitframe_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_clear,
    input  logic                 bit_stb,
    input  logic                 rx_bit,
    input  logic [CODE_W-1:0]    len_sel,
    output logic [MAX_LEN-1:0]   rx_char,
    output logic                 char_loaded,
    output logic                 overrun,
    output logic                 frame_end,
    output logic                 abort_seen,
    output logic                 zero_err
);
    rx_regs_t r_q, r_d;

    logic flag_hit, abort_hit, stuff_hit, zerr_hit;
    logic exit_bit, exit_ok, keep_in, flush;
    logic [SR_W-1:0]  sh;
    logic [IDX_W-1:0] ins_idx;

    bitframe_rx_linemon mon_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_clear),
        .stb      (bit_stb),
        .bit_in   (rx_bit),
        .flag_hit (flag_hit),
        .abort_hit(abort_hit),
        .stuff_hit(stuff_hit),
        .zerr_hit (zerr_hit)
    );

    assign keep_in = (r_q.st != ST_HUNT) && !stuff_hit;
    assign flush   = flag_hit || abort_hit;

    bitframe_rx_window #(.DEPTH(WIN_D)) win_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rx_clear),
        .stb    (bit_stb),
        .bit_in (rx_bit),
        .keep_in(keep_in),
        .flush  (flush),
        .out_bit(exit_bit),
        .out_ok (exit_ok)
    );

    always_comb begin
        r_d     = r_q;
        ins_idx = IDX_W'(MIN_LEN) + IDX_W'(r_q.len);
        sh      = r_q.sr >> 1;
        sh[ins_idx] = exit_bit;

        if (rx_clear) begin
            r_d        = '0;
            r_d.st     = ST_HUNT;
        end else if (flag_hit) begin
            if (r_q.st == ST_ASM) begin
                r_d.chr  = r_q.sr[SR_W-1:1];
                r_d.ovr  = r_q.ovr | r_q.loaded;
                r_d.fend = 1'b1;
                r_d.zerr = r_q.zerr | zerr_hit;
            end
            r_d.st  = ST_SYNC;
            r_d.len = len_sel;
            r_d.sr  = sr_seed(len_sel);
        end else if (abort_hit && (r_q.st != ST_HUNT)) begin
            r_d.abrt = 1'b1;
            r_d.st   = ST_HUNT;
        end else if (bit_stb && (r_q.st != ST_HUNT) && exit_ok) begin
            r_d.st = ST_ASM;
            if (!sh[0]) begin
                r_d.chr    = sh[SR_W-1:1];
                r_d.ovr    = r_q.ovr | r_q.loaded;
                r_d.loaded = 1'b1;
                r_d.len    = len_sel;
                r_d.sr     = sr_seed(len_sel);
            end else begin
                r_d.sr = sh;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_char     = r_q.chr;
    assign char_loaded = r_q.loaded;
    assign overrun     = r_q.ovr;
    assign frame_end   = r_q.fend;
    assign abort_seen  = r_q.abrt;
    assign zero_err    = r_q.zerr;

endmodule

// File: rtl/bitframe_rx_chk.sv
`timescale 1ns/1ps
module bitframe_rx_chk
    import bitframe_rx_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rx_clear,
    input logic               bit_stb,
    input logic               rx_bit,
    input logic [MAX_LEN-1:0] rx_char,
    input logic               char_loaded,
    input logic               overrun,
    input logic               frame_end,
    input logic               abort_seen,
    input logic               zero_err
);
    // R10
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clear |=> !(char_loaded || overrun || frame_end || abort_seen || zero_err));

    // R11
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !rx_clear) |=>
            $stable({rx_char, char_loaded, overrun, frame_end, abort_seen, zero_err}));

    // R4
    load_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(char_loaded) |-> $past(bit_stb));

    // R6
    overrun_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(char_loaded));

    // R7
    fend_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_end) |-> $past(bit_stb && !rx_bit));

    // R2
    abort_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_seen) |-> $past(bit_stb && rx_bit));

    // R9
    zerr_with_fend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_err) |-> frame_end);

endmodule

bind bitframe_rx bitframe_rx_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_clear   (rx_clear),
    .bit_stb    (bit_stb),
    .rx_bit     (rx_bit),
    .rx_char    (rx_char),
    .char_loaded(char_loaded),
    .overrun    (overrun),
    .frame_end  (frame_end),
    .abort_seen (abort_seen),
    .zero_err   (zero_err)
);

// File: tb/bitframe_rx_tb_top.sv
`timescale 1ns/1ps
module bitframe_rx_tb_top;
    import bitframe_rx_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n, rx_clear, bit_stb, rx_bit;
    logic [CODE_W-1:0]  len_sel;
    logic [MAX_LEN-1:0] rx_char;
    logic char_loaded, overrun, frame_end, abort_seen, zero_err;

    bitframe_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rx_clear(rx_clear), .bit_stb(bit_stb),
        .rx_bit(rx_bit), .len_sel(len_sel), .rx_char(rx_char),
        .char_loaded(char_loaded), .overrun(overrun), .frame_end(frame_end),
        .abort_seen(abort_seen), .zero_err(zero_err)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 200000) begin
            n_bad = n_bad + 1;
            $display("FAIL R1 watchdog: actual %0d cycles, expected completion below 200000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Stream builder
    logic sq [0:255];
    int sn, sp, run, last_data;

    function automatic logic [31:0] outs();
        return {19'b0, zero_err, abort_seen, frame_end, overrun, char_loaded, rx_char};
    endfunction

    function automatic logic [31:0] expv(input logic z, a, f, o, l, input logic [7:0] c);
        return {19'b0, z, a, f, o, l, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec = n_vec + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic s_new();
        sn = 0; sp = 0; run = 0;
    endtask

    task automatic push(input logic b);
        sq[sn] = b;
        sn = sn + 1;
    endtask

    task automatic push_flag();
        push(1'b0);
        for (int i = 0; i < 6; i++) push(1'b1);
        push(1'b0);
        run = 0;
    endtask

    task automatic push_char(input logic [7:0] v, input int len);
        for (int i = 0; i < len; i++) begin
            push(v[i]);
            last_data = sn - 1;
            run = v[i] ? run + 1 : 0;
            if (run == 5) begin
                push(1'b0);
                run = 0;
            end
        end
    endtask

    task automatic strobe(input logic b);
        @(negedge clk);
        bit_stb = 1'b1;
        rx_bit  = b;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic play_to(input int idx);
        while (sp <= idx) begin
            strobe(sq[sp]);
            sp = sp + 1;
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        rx_clear = 1'b1;
        @(negedge clk);
        rx_clear = 1'b0;
    endtask

    initial begin
        logic [31:0] snap;
        int p1, p2;
        rst_n = 1'b0; rx_clear = 1'b0; bit_stb = 1'b0; rx_bit = 1'b1; len_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset", outs(), expv(0, 0, 0, 0, 0, 8'h00));

        // R1 no assembly while hunting
        len_sel = 2'd3;
        s_new();
        for (int i = 0; i < 4; i++) push_char(8'h55, 8);
        play_to(sn - 1);
        chk("R1 hunt ignores data", outs(), expv(0, 0, 0, 0, 0, 8'h00));

        // R2 ones while hunting do not abort
        s_new();
        for (int i = 0; i < 12; i++) push(1'b1);
        play_to(sn - 1);
        chk("R2 hunt ones no abort", outs(), expv(0, 0, 0, 0, 0, 8'h00));

        // R3 R4 R5 R6 R7 sweep over every length and value
        for (int L = 5; L <= 8; L++) begin
            for (int v = 0; v < (1 << L); v++) begin
                do_clear();
                len_sel = CODE_W'(L - 5);
                s_new();
                push_flag();
                push_char(8'(v), L);
                push_flag();
                play_to(last_data + 7);
                chk("R4 R3 char value", outs(), expv(0, 0, 0, 0, 1, 8'(v)));
                play_to(sn - 1);
                chk("R7 R6 frame end marker", outs(),
                    expv(0, 0, 1, 1, 1, 8'((1 << (L - 1)) - 1)));
            end
        end

        // R8 back-to-back flags
        do_clear();
        len_sel = 2'd3;
        s_new();
        push_flag(); push_flag(); push_flag();
        play_to(sn - 1);
        chk("R8 idle flags", outs(), expv(0, 0, 0, 0, 0, 8'h00));
        s_new();
        push_char(8'h2A, 8);
        push_flag();
        play_to(sn - 1);
        chk("R8 frame after idle flags", outs(), expv(0, 0, 1, 1, 1, 8'h7F));

        // R2 abort while synchronized, then hunting, then recovery
        do_clear();
        len_sel = 2'd3;
        s_new();
        push_flag();
        push(1'b1); push(1'b0);
        for (int i = 0; i < 8; i++) push(1'b1);
        play_to(sn - 1);
        chk("R2 abort", outs(), expv(0, 1, 0, 0, 0, 8'h00));
        s_new();
        push(1'b0);
        push_char(8'h93, 8);
        push_char(8'h41, 8);
        play_to(sn - 1);
        chk("R2 hunting after abort", outs(), expv(0, 1, 0, 0, 0, 8'h00));
        s_new();
        push_flag();
        push_char(8'hC3, 8);
        push_flag();
        play_to(last_data + 7);
        chk("R2 resync after abort", outs(), expv(0, 1, 0, 0, 1, 8'hC3));

        // R9 zero error: five unstuffed ones then a flag
        do_clear();
        len_sel = 2'd0;
        s_new();
        push_flag();
        for (int i = 0; i < 5; i++) push(1'b1);
        last_data = sn - 1;
        push_flag();
        play_to(last_data + 7);
        chk("R9 char before missing zero", outs(), expv(0, 0, 0, 0, 1, 8'h1F));
        play_to(sn - 1);
        chk("R9 zero error", outs(), expv(1, 0, 1, 1, 1, 8'h0F));

        // R10 clear
        do_clear();
        chk("R10 clear", outs(), expv(0, 0, 0, 0, 0, 8'h00));
        s_new();
        push_char(8'h66, 8);
        push_flag();
        play_to(sn - 1);
        chk("R10 hunting after clear", outs(), expv(0, 0, 0, 0, 0, 8'h00));

        // R5 R6 length change inside a frame
        do_clear();
        len_sel = 2'd0;
        s_new();
        push_flag();
        push_char(8'h13, 5);
        p1 = last_data;
        push_char(8'hA6, 8);
        p2 = last_data;
        push_flag();
        play_to(7);
        len_sel = 2'd3;
        play_to(p1 + 7);
        chk("R5 first char length 5", outs(), expv(0, 0, 0, 0, 1, 8'h13));
        play_to(p2 + 7);
        chk("R5 R6 second char length 8 overrun", outs(), expv(0, 0, 0, 1, 1, 8'hA6));

        // R11 no change without strobe
        snap = outs();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_bit = ~rx_bit;
        end
        chk("R11 hold without strobe", outs(), snap);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule